// File: doc/BRIEF.md
# Dual-Action Timer Event Channel

This block is one channel of a timer subsystem. It owns two event sets, called first and second. Each set holds a 24-bit match value, a 24-bit capture value, a small configuration word, an arm bit and an event flag. An armed set fires on one of two triggers. The first trigger is its match value compared against one of two free-running time bases, using either an equal-only compare or a reached (greater-or-equal) compare. The second trigger is a rising edge on the channel's single input pin. When a set fires, it latches the selected time base into its capture register, raises its flag, disarms itself and applies its configured action to the channel's single output pin.

A linking mode decides how the second set depends on the first. The sets can be independent. The first event can open the second, so the second cannot fire until the first has fired. The first event can also shut the second, so the second may fire only until the first has fired. A small sequencer tracks this with four named states:

- FREE: the sets are independent.
- WAIT_FIRST: the first event has not happened yet.
- SECOND_OPEN: the first event has happened and the second set may fire.
- SECOND_SHUT: the first event has happened and the second set may not fire.

The sequencer has these transitions:

- A control write enters WAIT_FIRST when the mode is 01 or 10, and FREE for any other mode.
- In WAIT_FIRST, the first set firing moves the sequencer to SECOND_OPEN in mode 01, or to SECOND_SHUT in mode 10.
- No other event moves it.

Software programs the block through a single-cycle write port. It watches the flags and clears them with a one-cycle clear pulse per set.

Top module: `dual_event_channel`

## Requirements
- R1: After reset, pin_out is 0, both flags are 0, both capture outputs are 0, neither set is armed, and the linking mode is 00.
- R2: Write map, applied on a clock edge where wr_en is 1. Address 0 writes the first match value and address 1 the second. Address 2 writes the first configuration and address 3 the second. Address 4 is control: bits 1:0 are the mode, bit 2 arms the first set and bit 3 arms the second. Addresses 5 to 7 change nothing. Configuration bits are: bit 0 selects the time base (0 = tb_a, 1 = tb_b), bit 1 selects the reached compare, bits 3:2 select the pin action, and bit 4 selects the input-edge trigger.
- R3: With bit 1 clear, a set's compare hits only in a cycle where the selected time base equals its match value.
- R4: With bit 1 set, the compare hits when the 24-bit modulo difference (time base minus match) has bit 23 clear. This includes the case where the time base has wrapped past zero.
- R5: Bit 0 of the configuration decides which time base is compared and captured, and the other time base has no effect on that set.
- R6: When a set fires, its capture output shows the selected time base from the firing cycle and its flag reads 1 from the next cycle. The flag stays at 1 until flag_clr for that set is pulsed. If a fire and a clear happen in the same cycle, the flag ends at 1.
- R7: A set fires only while armed and is disarmed by its own fire, so one arming gives at most one event.
- R8: With bit 4 set, the set fires on a rising edge of pin_in (0 in the previous cycle, 1 now) and ignores its compare.
- R9: Pin actions are 00 none, 01 drive 1, 10 drive 0 and 11 invert. When both sets fire in one cycle, the first set's action is applied and then the second's. pin_out changes in no cycle without a fire.
- R10: Mode 00 (or 11) lets the two sets fire independently, including in the same cycle.
- R11: Mode 01 keeps the second set from firing until a cycle after the first set has fired.
- R12: Mode 10 lets the second set fire until the first set fires. It never lets the second set fire in the same cycle as the first or after it.
- R13: Every control write restarts the link sequence, so a mode of 01 or 10 goes back to waiting for the first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_a | input | 24 | First free-running time base |
| tb_b | input | 24 | Second free-running time base |
| pin_in | input | 1 | Channel input pin |
| pin_out | output | 1 | Channel output pin (registered) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 24 | Register write data |
| flag_clr | input | 2 | Per-set flag clear pulse (bit 0 = first set) |
| event_flag | output | 2 | Per-set event flags (bit 0 = first set) |
| cap_first | output | 24 | Capture value of the first set |
| cap_second | output | 24 | Capture value of the second set |

## Verification
The sharpest collisions are cycles where both sets hit together. In that cycle the pin must show the first action followed by the second, and mode 10 must suppress the second set. The bench provokes this directly by giving both sets the same match value on one time base. It repeats the case with the drive-1-then-invert and drive-0-then-drive-1 action pairs, and it judges the pin and flags one cycle later. A flag clear landing on the same edge as a fire is also forced, and the flag must stay set. A random phase with small time base values makes both kinds of overlap common, and a cycle model in the bench judges every output after every edge.

// File: rtl/dac_pkg.sv
package dac_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N_SETS = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MATCH0 = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG0   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd4;
    localparam int               ARM_BIT0    = 2;

    typedef enum logic [1:0] {
        MODE_INDEP  = 2'b00,
        MODE_ENABLE = 2'b01,
        MODE_BLOCK  = 2'b10,
        MODE_RSVD   = 2'b11
    } link_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_HIGH   = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        SEQ_FREE,
        SEQ_WAIT_FIRST,
        SEQ_SECOND_OPEN,
        SEQ_SECOND_SHUT
    } seq_state_e;

    // bit 4 edge trigger, bits 3:2 action, bit 1 reached compare, bit 0 time base
    typedef struct packed {
        logic     edge_trig;
        pin_act_e act;
        logic     ge_cmp;
        logic     tb_sel;
    } set_cfg_t;

    function automatic logic apply_act(input logic level, input pin_act_e act);
        logic r;
        unique case (act)
            ACT_NONE:   r = level;
            ACT_HIGH:   r = 1'b1;
            ACT_LOW:    r = 1'b0;
            ACT_TOGGLE: r = ~level;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dac_event_set.sv
module dac_event_set
    import dac_pkg::*;
#(
    parameter int TB_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb_a,
    input  logic [TB_W-1:0] tb_b,
    input  logic            pin_rise,
    input  logic            gate,
    input  logic            wr_match,
    input  logic            wr_cfg,
    input  logic            arm_req,
    input  logic            flag_clr,
    input  logic [TB_W-1:0] wr_data,
    output logic            fire,
    output logic            armed,
    output logic            flag,
    output logic [TB_W-1:0] capture,
    output pin_act_e        act,
    output logic            tb_sel
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CFG_W = $bits(set_cfg_t);

    logic [TB_W-1:0] match_q;
    logic [TB_W-1:0] cap_q;
    logic [TB_W-1:0] tb_now;
    logic [TB_W-1:0] gap;
    set_cfg_t        cfg_q;
    logic            armed_q;
    logic            flag_q;
    logic            reached;
    logic            hit;

    always_comb begin
        tb_now  = cfg_q.tb_sel ? tb_b : tb_a;
        gap     = tb_now - match_q;
        reached = cfg_q.ge_cmp ? ~gap[TB_W-1] : (tb_now == match_q);
        hit     = cfg_q.edge_trig ? pin_rise : reached;
    end

    assign fire = armed_q & gate & hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            cfg_q   <= '0;
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
            cap_q   <= '0;
        end else begin
            if (wr_match) match_q <= wr_data;
            if (wr_cfg)   cfg_q   <= set_cfg_t'(wr_data[CFG_W-1:0]);
            if (arm_req)   armed_q <= 1'b1;
            else if (fire) armed_q <= 1'b0;
            if (fire) begin
                flag_q <= 1'b1;
                cap_q  <= tb_now;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign armed   = armed_q;
    assign flag    = flag_q;
    assign capture = cap_q;
    assign act     = cfg_q.act;
    assign tb_sel  = cfg_q.tb_sel;
endmodule

// File: rtl/dac_link_seq.sv
module dac_link_seq
    import dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  link_mode_e mode_in,
    input  logic       fire_first,
    output logic       gate_second,
    output seq_state_e state_o,
    output link_mode_e mode_o
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_state_e state_q;
    seq_state_e state_d;
    link_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= MODE_INDEP;
        else if (mode_wr) mode_q <= mode_in;
    end

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = (mode_in == MODE_ENABLE || mode_in == MODE_BLOCK)
                      ? SEQ_WAIT_FIRST : SEQ_FREE;
        end else begin
            unique case (state_q)
                SEQ_FREE:        state_d = SEQ_FREE;
                SEQ_WAIT_FIRST:  if (fire_first)
                                     state_d = (mode_q == MODE_ENABLE)
                                               ? SEQ_SECOND_OPEN : SEQ_SECOND_SHUT;
                SEQ_SECOND_OPEN: state_d = SEQ_SECOND_OPEN;
                SEQ_SECOND_SHUT: state_d = SEQ_SECOND_SHUT;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SEQ_FREE:        gate_second = 1'b1;
            SEQ_WAIT_FIRST:  gate_second = (mode_q == MODE_BLOCK) && !fire_first;
            SEQ_SECOND_OPEN: gate_second = 1'b1;
            SEQ_SECOND_SHUT: gate_second = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/dac_pin_drive.sv
module dac_pin_drive
    import dac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_in,
    input  logic     fire_first,
    input  logic     fire_second,
    input  pin_act_e act_first,
    input  pin_act_e act_second,
    output logic     pin_rise,
    output logic     pin_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic pin_in_q;
    logic level_q;
    logic level_d;

    assign pin_rise = pin_in & ~pin_in_q;

    always_comb begin
        level_d = level_q;
        if (fire_first)  level_d = apply_act(level_d, act_first);
        if (fire_second) level_d = apply_act(level_d, act_second);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_in_q <= 1'b0;
            level_q  <= 1'b0;
        end else begin
            pin_in_q <= pin_in;
            level_q  <= level_d;
        end
    end

    assign pin_out = level_q;
endmodule

// File: rtl/dual_event_channel.sv
module dual_event_channel
    import dac_pkg::*;
#(
    parameter int TB_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TB_W-1:0]   tb_a,
    input  logic [TB_W-1:0]   tb_b,
    input  logic              pin_in,
    output logic              pin_out,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TB_W-1:0]   wr_data,
    input  logic [1:0]        flag_clr,
    output logic [1:0]        event_flag,
    output logic [TB_W-1:0]   cap_first,
    output logic [TB_W-1:0]   cap_second
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N_SETS-1:0] fire;
    logic [N_SETS-1:0] armed;
    logic [N_SETS-1:0] gate;
    logic [N_SETS-1:0] wr_match;
    logic [N_SETS-1:0] wr_cfg;
    logic [N_SETS-1:0] arm_req;
    logic [N_SETS-1:0] tb_sel;
    logic [TB_W-1:0]   cap_q [N_SETS];
    pin_act_e          act   [N_SETS];
    logic              mode_wr;
    logic              pin_rise;
    logic              gate_second;
    seq_state_e        seq_state;
    link_mode_e        seq_mode;

    assign mode_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign gate    = {gate_second, 1'b1};

    for (genvar g = 0; g < N_SETS; g++) begin : g_set
        assign wr_match[g] = wr_en && (wr_addr == ADDR_MATCH0 + ADDR_W'(g));
        assign wr_cfg[g]   = wr_en && (wr_addr == ADDR_CFG0 + ADDR_W'(g));
        assign arm_req[g]  = mode_wr && wr_data[ARM_BIT0 + g];

        dac_event_set #(.TB_W(TB_W)) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .tb_a     (tb_a),
            .tb_b     (tb_b),
            .pin_rise (pin_rise),
            .gate     (gate[g]),
            .wr_match (wr_match[g]),
            .wr_cfg   (wr_cfg[g]),
            .arm_req  (arm_req[g]),
            .flag_clr (flag_clr[g]),
            .wr_data  (wr_data),
            .fire     (fire[g]),
            .armed    (armed[g]),
            .flag     (event_flag[g]),
            .capture  (cap_q[g]),
            .act      (act[g]),
            .tb_sel   (tb_sel[g])
        );
    end

    dac_link_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_in     (link_mode_e'(wr_data[1:0])),
        .fire_first  (fire[0]),
        .gate_second (gate_second),
        .state_o     (seq_state),
        .mode_o      (seq_mode)
    );

    dac_pin_drive u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .fire_first  (fire[0]),
        .fire_second (fire[1]),
        .act_first   (act[0]),
        .act_second  (act[1]),
        .pin_rise    (pin_rise),
        .pin_out     (pin_out)
    );

    assign cap_first  = cap_q[0];
    assign cap_second = cap_q[1];
endmodule

// File: rtl/dac_checker.sv
module dac_checker
    import dac_pkg::*;
#(
    parameter int TB_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TB_W-1:0] tb_a,
    input logic [TB_W-1:0] tb_b,
    input logic [1:0]      fire,
    input logic [1:0]      armed,
    input logic [1:0]      arm_req,
    input logic [1:0]      event_flag,
    input logic [1:0]      tb_sel,
    input logic            pin_out,
    input logic [TB_W-1:0] cap_first,
    input logic [TB_W-1:0] cap_second,
    input logic            mode_wr,
    input seq_state_e      seq_state,
    input link_mode_e      seq_mode
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_flag_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire[0] |=> event_flag[0]);
    assert_flag_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> event_flag[1]);
    assert_capture_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire[0] |=> cap_first == $past(tb_sel[0] ? tb_b : tb_a));
    assert_capture_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> cap_second == $past(tb_sel[1] ? tb_b : tb_a));
    assert_one_shot_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[0] && !arm_req[0]) |=> !armed[0]);
    assert_one_shot_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[1] && !arm_req[1]) |=> !armed[1]);
    assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == 2'b00) |=> $stable(pin_out));
    assert_enable_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT_FIRST && seq_mode == MODE_ENABLE) |-> !fire[1]);
    assert_enable_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT_FIRST && seq_mode == MODE_ENABLE && fire[0] && !mode_wr)
        |=> seq_state == SEQ_SECOND_OPEN);
    assert_block_same_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT_FIRST && seq_mode == MODE_BLOCK && fire[0]) |-> !fire[1]);
    assert_block_shut_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_SECOND_SHUT) |-> !fire[1]);
    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (seq_state == SEQ_WAIT_FIRST || seq_state == SEQ_FREE));
endmodule

bind dual_event_channel dac_checker #(.TB_W(TB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_a       (tb_a),
    .tb_b       (tb_b),
    .fire       (fire),
    .armed      (armed),
    .arm_req    (arm_req),
    .event_flag (event_flag),
    .tb_sel     (tb_sel),
    .pin_out    (pin_out),
    .cap_first  (cap_first),
    .cap_second (cap_second),
    .mode_wr    (mode_wr),
    .seq_state  (seq_state),
    .seq_mode   (seq_mode)
);

// File: tb/sim_dual_event_channel.sv
module sim_dual_event_channel;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [23:0] IDL = 24'h800000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] tb_a = IDL, tb_b = IDL;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  event_flag;
    logic [23:0] cap_first, cap_second;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic model_on = 1'b0;

    always #2.5 clk = ~clk;

    dual_event_channel u0 (
        .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b), .pin_in(pin_in),
        .pin_out(pin_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .event_flag(event_flag),
        .cap_first(cap_first), .cap_second(cap_second)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic f_reached(input logic [23:0] t, input logic [23:0] m, input logic ge);
        logic [23:0] d;
        d = t - m;
        return ge ? !d[23] : (t == m);
    endfunction

    function automatic logic f_act(input logic p, input logic [1:0] a);
        case (a)
            2'b01:   return 1'b1;
            2'b10:   return 1'b0;
            2'b11:   return !p;
            default: return p;
        endcase
    endfunction

    // cycle model written from the requirements
    logic [23:0] m_match [2];
    logic [4:0]  m_cfg   [2];
    logic [23:0] m_cap   [2];
    logic [1:0]  m_arm, m_flag, m_hit, m_fire;
    logic [1:0]  m_mode;
    int          m_st;
    logic        m_pin, m_pinq, m_rise, m_g1;
    logic [23:0] m_tv;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_match[i] = '0; m_cfg[i] = '0; m_cap[i] = '0;
            end
            m_arm = '0; m_flag = '0; m_mode = '0; m_st = 0; m_pin = 0; m_pinq = 0;
        end else begin
            m_rise = pin_in && !m_pinq;
            for (int i = 0; i < 2; i++) begin
                m_tv = m_cfg[i][0] ? tb_b : tb_a;
                m_hit[i] = m_cfg[i][4] ? m_rise : f_reached(m_tv, m_match[i], m_cfg[i][1]);
            end
            m_fire[0] = m_arm[0] && m_hit[0];
            case (m_st)
                1:       m_g1 = (m_mode == 2'b10) && !m_fire[0];
                3:       m_g1 = 1'b0;
                default: m_g1 = 1'b1;
            endcase
            m_fire[1] = m_arm[1] && m_hit[1] && m_g1;
            if (m_fire[0]) m_pin = f_act(m_pin, m_cfg[0][3:2]);
            if (m_fire[1]) m_pin = f_act(m_pin, m_cfg[1][3:2]);
            for (int i = 0; i < 2; i++) begin
                if (flag_clr[i]) m_flag[i] = 1'b0;
                if (m_fire[i]) begin
                    m_flag[i] = 1'b1;
                    m_cap[i]  = m_cfg[i][0] ? tb_b : tb_a;
                    m_arm[i]  = 1'b0;
                end
            end
            if (wr_en && wr_addr == 3'd4) begin
                m_st   = (wr_data[1:0] == 2'b01 || wr_data[1:0] == 2'b10) ? 1 : 0;
                m_mode = wr_data[1:0];
                if (wr_data[2]) m_arm[0] = 1'b1;
                if (wr_data[3]) m_arm[1] = 1'b1;
            end else if (m_st == 1 && m_fire[0]) begin
                m_st = (m_mode == 2'b01) ? 2 : 3;
            end
            if (wr_en && wr_addr == 3'd0) m_match[0] = wr_data;
            if (wr_en && wr_addr == 3'd1) m_match[1] = wr_data;
            if (wr_en && wr_addr == 3'd2) m_cfg[0] = wr_data[4:0];
            if (wr_en && wr_addr == 3'd3) m_cfg[1] = wr_data[4:0];
            m_pinq = pin_in;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R2/R9 model pin_out", {23'd0, pin_out}, {23'd0, m_pin});
            check("R2/R6 model event_flag", {22'd0, event_flag}, {22'd0, m_flag});
            check("R2/R6 model cap_first", cap_first, m_cap[0]);
            check("R2/R6 model cap_second", cap_second, m_cap[1]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic cyc(input logic [23:0] ta, input logic [23:0] tv, input logic p,
                       input logic w, input logic [2:0] a, input logic [23:0] d,
                       input logic [1:0] c);
        @(negedge clk);
        tb_a = ta; tb_b = tv; pin_in = p; wr_en = w; wr_addr = a; wr_data = d; flag_clr = c;
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        cyc(IDL, IDL, 1'b0, 1'b1, a, d, 2'b00);
    endtask

    task automatic idle();
        cyc(IDL, IDL, 1'b0, 1'b0, 3'd0, 24'd0, 2'b00);
    endtask

    task automatic clr();
        cyc(IDL, IDL, 1'b0, 1'b0, 3'd0, 24'd0, 2'b11);
    endtask

    task automatic at(input logic [23:0] ta, input logic [23:0] tv, input logic p);
        cyc(ta, tv, p, 1'b0, 3'd0, 24'd0, 2'b00);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        idle();
        // R1 reset state
        check("R1 pin_out", {23'd0, pin_out}, 24'd0);
        check("R1 event_flag", {22'd0, event_flag}, 24'd0);
        check("R1 cap_first", cap_first, 24'd0);
        check("R1 cap_second", cap_second, 24'd0);

        // R3 equal compare, R9 drive 1
        wr(3'd0, 24'd100); wr(3'd2, 24'h04); wr(3'd4, 24'h04);
        at(24'd99, IDL, 0); idle();
        check("R3 no hit off by one", {22'd0, event_flag}, 24'd0);
        at(24'd100, IDL, 0); idle();
        check("R3 equal hit flag", {22'd0, event_flag}, 24'd1);
        check("R6 capture value", cap_first, 24'd100);
        check("R9 drive high", {23'd0, pin_out}, 24'd1);
        clr(); idle();
        check("R6 flag cleared", {22'd0, event_flag}, 24'd0);
        at(24'd100, IDL, 0); idle();
        check("R7 one shot", {22'd0, event_flag}, 24'd0);

        // R4 reached compare with wrap, R5 time base select, invert
        wr(3'd1, 24'hFFFFF0); wr(3'd3, 24'h0F); wr(3'd4, 24'h08);
        at(24'hFFFFF5, 24'h7FFFF0, 0); idle();
        check("R5 other base ignored", {22'd0, event_flag}, 24'd0);
        at(IDL, 24'h000005, 0); idle();
        check("R4 wrapped reach", {22'd0, event_flag}, 24'd2);
        check("R4 capture", cap_second, 24'h000005);
        check("R9 invert", {23'd0, pin_out}, 24'd0);

        // R8 input edge trigger
        clr();
        wr(3'd2, 24'h14); wr(3'd4, 24'h04);
        at(24'h123456, IDL, 1); idle();
        check("R8 edge flag", {22'd0, event_flag}, 24'd1);
        check("R8 edge capture", cap_first, 24'h123456);
        check("R8 edge pin", {23'd0, pin_out}, 24'd1);

        // R11 enable mode
        clr();
        wr(3'd0, 24'd10); wr(3'd1, 24'd20); wr(3'd2, 24'h00); wr(3'd3, 24'h08);
        wr(3'd4, 24'h0D);
        at(24'd20, IDL, 0); idle();
        check("R11 second held", {22'd0, event_flag}, 24'd0);
        at(24'd10, IDL, 0); idle();
        check("R11 first fires", {22'd0, event_flag}, 24'd1);
        at(24'd20, IDL, 0); idle();
        check("R11 second opened", {22'd0, event_flag}, 24'd3);
        check("R11 pin low", {23'd0, pin_out}, 24'd0);

        // R12 block mode
        clr();
        wr(3'd3, 24'h04); wr(3'd4, 24'h0E);
        at(24'd20, IDL, 0); idle();
        check("R12 second before first", {22'd0, event_flag}, 24'd2);
        check("R12 pin high", {23'd0, pin_out}, 24'd1);
        wr(3'd4, 24'h0E);
        at(24'd10, IDL, 0); idle();
        check("R12 first fires", {22'd0, event_flag}, 24'd3);
        clr();
        at(24'd20, IDL, 0); idle();
        check("R12 second shut", {22'd0, event_flag}, 24'd0);
        wr(3'd1, 24'd10); wr(3'd4, 24'h0E); clr();
        at(24'd10, IDL, 0); idle();
        check("R12 same cycle first wins", {22'd0, event_flag}, 24'd1);
        clr(); wr(3'd4, 24'h0A);
        at(24'd10, IDL, 0); idle();
        check("R13 restart reopens", {22'd0, event_flag}, 24'd2);

        // R10 independent, both in one cycle, R9 order
        clr();
        wr(3'd0, 24'd50); wr(3'd1, 24'd50); wr(3'd2, 24'h04); wr(3'd3, 24'h0C);
        wr(3'd4, 24'h0C);
        at(24'd50, IDL, 0); idle();
        check("R10 both fire", {22'd0, event_flag}, 24'd3);
        check("R9 high then invert", {23'd0, pin_out}, 24'd0);
        wr(3'd2, 24'h08); wr(3'd3, 24'h04); wr(3'd4, 24'h0C);
        at(24'd50, IDL, 0); idle();
        check("R9 low then high", {23'd0, pin_out}, 24'd1);

        // R6 fire and clear in one cycle
        clr();
        wr(3'd2, 24'h00); wr(3'd0, 24'd77); wr(3'd4, 24'h04);
        cyc(24'd77, IDL, 1'b0, 1'b0, 3'd0, 24'd0, 2'b01); idle();
        check("R6 fire beats clear", {22'd0, event_flag}, 24'd1);

        // random phase, judged by the model
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] d;
            d = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'($urandom_range(0, 15));
            cyc(24'($urandom_range(0, 15)), 24'($urandom_range(0, 15)),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                3'($urandom_range(0, 7)), d, 2'($urandom_range(0, 3)) & {2{$urandom_range(0, 2) == 0}});
        end
        idle(); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule